// File: doc/BRIEF.md
# I2C Bus Event Sniffer

This block listens to the two wires of an I2C bus without ever driving them. It turns the activity it sees into a stream of short tokens. A token marks a start condition, a stop condition, a captured data byte, or the acknowledge level on the ninth clock. The block has two inputs for the raw line levels, `scl_in` and `sda_in`. Each line is synchronised, then cleaned by a short agreement filter, and then decoded against the system clock. The system clock must run at least twenty times faster than SCL.

Decoded tokens go into an internal FIFO, so bursts of bus traffic at 400 kHz are absorbed while a slower consumer catches up. The consumer drains one token per accepted handshake on a valid/ready port, typically to feed a serial link. If the FIFO is full when a new event arrives, that event is discarded and a sticky overflow flag is raised. The flag stays set until reset or until the clear input is pulsed.

Each token is 10 bits. Bits [9:8] give the kind:
- 00: start
- 01: stop
- 10: data byte, with the value in [7:0]
- 11: acknowledge, with [0] set to 1 for a NACK and [7:1] set to zero

Start and stop tokens carry zero in [7:0].

Top module: `i2c_snf_top`

## Requirements
- R1: SDA falling while SCL is high produces a start token (kind 00, payload 0).
- R2: SDA rising while SCL is high produces a stop token (kind 01, payload 0).
- R3: A start while a transfer is open produces another start token, with no stop token before it.
- R4: Within an open transfer, eight data bits sampled on rising SCL edges, most significant first, produce a data token (kind 10) carrying the byte.
- R5: The ninth rising SCL edge produces an acknowledge token (kind 11) with bit [0] equal to the sampled SDA level: 0 for ACK, 1 for NACK.
- R6: Clock pulses outside an open transfer (before any start, or after a stop) produce no tokens.
- R7: A start or stop in the middle of a byte discards the partial byte, and the next byte is framed from its first bit.
- R8: Tokens leave in event order, one per cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the token holds steady. Up to 4096 tokens are stored.
- R9: An event that arrives while 4096 tokens are stored is dropped, and `overflow` goes high.
- R10: Once set, `overflow` stays high until reset or a `clr_ovf` pulse.
- R11: A pulse on SCL or SDA shorter than three system clocks has no effect on the decoded tokens.
- R12: After reset, `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| clr_ovf | input | 1 | Clears the overflow flag |
| out_ready | input | 1 | Consumer accepts the current token |
| out_valid | output | 1 | A token is available |
| out_token | output | 10 | Current token: kind in [9:8], payload in [7:0] |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
Each bus event reaches the output about eight system clocks after the line change that causes it:
- two synchroniser stages
- three filter samples
- the filter output register
- the decoder's push register
- the FIFO write

The bench never samples at a fixed offset. A scoreboard queue is loaded with the expected token when the stimulus is issued, and a monitor compares every accepted handshake, in order, against the head of that queue.

Since each bus phase lasts five clocks and events are well separated, token order alone decides the outcome. The overflow flag is checked only after the bus has been quiet for several phases, so the dropped event has been fully processed before the check.

// File: rtl/i2c_snf_pkg.sv
package i2c_snf_pkg;
   localparam int TOK_W = 10;

   typedef enum logic [1:0] {
      TK_START = 2'b00,
      TK_STOP  = 2'b01,
      TK_DATA  = 2'b10,
      TK_ACK   = 2'b11
   } tok_kind_e;

   function automatic logic [TOK_W-1:0] mk_tok(input tok_kind_e k, input logic [7:0] p);
      return {k, p};
   endfunction
endpackage

// File: rtl/i2c_snf_filt.sv
module i2c_snf_filt #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_LEN-1:0] sync_q;
   logic [FILT_LEN-1:0] win_q;

   initial begin
      sync_len_chk: assert (SYNC_LEN >= 2) else $error("SYNC_LEN must be at least 2");
      filt_len_chk: assert (FILT_LEN >= 2) else $error("FILT_LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         win_q  <= '1;
         dout   <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_LEN-2:0], din};
         win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
         if (&win_q)
            dout <= 1'b1;
         else if (~|win_q)
            dout <= 1'b0;
      end
   end

   // R11
   filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> (($past(win_q) == '1) || ($past(win_q) == '0)));
endmodule

// File: rtl/i2c_snf_decode.sv
module i2c_snf_decode
   import i2c_snf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             sda_f,
   output logic             push_vld,
   output logic [TOK_W-1:0] push_tok
);
   logic       scl_d, sda_d;
   logic       in_xfer;
   logic [3:0] bit_cnt;
   logic [6:0] shreg;
   logic       start_ev, stop_ev, rise_ev;

   always_comb begin
      start_ev = scl_f && scl_d && sda_d && !sda_f;
      stop_ev  = scl_f && scl_d && !sda_d && sda_f;
      rise_ev  = scl_f && !scl_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
         in_xfer  <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         push_vld <= 1'b0;
         push_tok <= '0;
      end else begin
         scl_d    <= scl_f;
         sda_d    <= sda_f;
         push_vld <= 1'b0;
         if (start_ev) begin
            in_xfer  <= 1'b1;
            bit_cnt  <= '0;
            push_vld <= 1'b1;
            push_tok <= mk_tok(TK_START, 8'h00);
         end else if (stop_ev) begin
            in_xfer  <= 1'b0;
            bit_cnt  <= '0;
            push_vld <= 1'b1;
            push_tok <= mk_tok(TK_STOP, 8'h00);
         end else if (rise_ev && in_xfer) begin
            if (bit_cnt == 4'd8) begin
               bit_cnt  <= '0;
               push_vld <= 1'b1;
               push_tok <= mk_tok(TK_ACK, {7'b0, sda_f});
            end else begin
               shreg   <= {shreg[5:0], sda_f};
               bit_cnt <= bit_cnt + 4'd1;
               if (bit_cnt == 4'd7) begin
                  push_vld <= 1'b1;
                  push_tok <= mk_tok(TK_DATA, {shreg, sda_f});
               end
            end
         end
      end
   end

   // R4
   bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8);

   // R6
   data_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && push_tok[9] == 1'b1) |-> $past(in_xfer));

   // R7
   frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev || stop_ev) |=> (bit_cnt == 4'd0));
endmodule

// File: rtl/i2c_snf_fifo.sv
module i2c_snf_fifo #(
   parameter int DEPTH = 4096,
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop_ready,
   input  logic             clr_ovf,
   output logic             valid,
   output logic [WIDTH-1:0] dout,
   output logic             ovf
);
   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      count;
   logic             full, do_push, do_pop;

   initial begin
      depth_pow2_chk: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
   end

   always_comb begin
      full    = (count == DEPTH[AW:0]);
      valid   = (count != '0);
      do_push = push && !full;
      do_pop  = valid && pop_ready;
      dout    = mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
         if (clr_ovf)
            ovf <= 1'b0;
         else if (push && full)
            ovf <= 1'b1;
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH[AW:0]);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);

   // R8
   hold_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop_ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/i2c_snf_top.sv
module i2c_snf_top
   import i2c_snf_pkg::*;
#(
   parameter int DEPTH    = 4096,
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             clr_ovf,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [TOK_W-1:0] out_token,
   output logic             overflow
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_lines, filt_lines;
   logic               push_vld;
   logic [TOK_W-1:0]   push_tok;

   assign raw_lines = {sda_in, scl_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2c_snf_filt #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) i_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_lines[g]),
         .dout (filt_lines[g])
      );
   end

   i2c_snf_decode i_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[0]),
      .sda_f   (filt_lines[1]),
      .push_vld(push_vld),
      .push_tok(push_tok)
   );

   i2c_snf_fifo #(.DEPTH(DEPTH), .WIDTH(TOK_W)) i_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_vld),
      .din      (push_tok),
      .pop_ready(out_ready),
      .clr_ovf  (clr_ovf),
      .valid    (out_valid),
      .dout     (out_token),
      .ovf      (overflow)
   );

   // R12
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !overflow));
endmodule

// File: tb/test_i2c_snf_top.sv
module test_i2c_snf_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       clr_ovf = 1'b0, out_ready = 1'b1;
   logic       out_valid, overflow;
   logic [9:0] out_token;

   int checks = 0, errors = 0;
   logic [9:0] exp_q[$];
   bit done = 0;
   localparam int Q = 5;

   always #2 clk = ~clk;

   i2c_snf_top i_i2c_snf_top (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .clr_ovf(clr_ovf), .out_ready(out_ready), .out_valid(out_valid),
      .out_token(out_token), .overflow(overflow)
   );

   task automatic wq(input int n = Q);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: scoreboard compare on every accepted token
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8: actual %h expected no token", out_token);
         end else begin
            chk("R8 token order", {22'b0, out_token}, {22'b0, exp_q.pop_front()});
         end
      end
   end

   // R1/R3 start token (kind 00)
   task automatic bus_start(input bit expect_tok = 1);
      if (expect_tok) exp_q.push_back(10'h000);
      sda_in = 1'b1; wq(); scl_in = 1'b1; wq(); sda_in = 1'b0; wq(); scl_in = 1'b0; wq();
   endtask

   // R2 stop token (kind 01)
   task automatic bus_stop(input bit expect_tok = 1);
      if (expect_tok) exp_q.push_back(10'h100);
      sda_in = 1'b0; wq(); scl_in = 1'b1; wq(); sda_in = 1'b1; wq();
   endtask

   task automatic bus_bit(input bit b);
      sda_in = b; wq(); scl_in = 1'b1; wq(2 * Q); scl_in = 1'b0; wq();
   endtask

   // R4 data (kind 10), R5 ack (kind 11, bit0 = NACK)
   task automatic bus_byte(input logic [7:0] b, input bit nack);
      exp_q.push_back({2'b10, b});
      exp_q.push_back({2'b11, 7'b0, nack});
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      bus_bit(nack);
   endtask

   task automatic drain_check(input string req);
      wq(30);
      chk(req, exp_q.size(), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wq(4);
      rst_n = 1'b1;
      wq(2);
      // R12
      chk("R12 out_valid", out_valid, 0);
      chk("R12 overflow", overflow, 0);

      // R6: clocking before any start gives nothing
      scl_in = 1'b0; wq();
      for (int i = 0; i < 9; i++) bus_bit(i[0]);
      scl_in = 1'b1; sda_in = 1'b1; wq(3 * Q);
      chk("R6 idle bits", out_valid, 0);

      // R1 R2 R4 R5: write with ACKs, read byte NACK
      bus_start();
      bus_byte(8'h18, 1'b0);
      bus_byte(8'h80, 1'b0);
      bus_stop();
      bus_start();
      bus_byte(8'hA5, 1'b1);
      bus_stop();
      drain_check("R4 R5 sequence");

      // R3: repeated start without stop
      bus_start();
      bus_byte(8'h18, 1'b0);
      bus_byte(8'h0E, 1'b0);
      bus_start();
      bus_byte(8'h19, 1'b0);
      bus_byte(8'h3C, 1'b1);
      bus_stop();
      drain_check("R3 repeated start");

      // R6: bits after stop ignored
      scl_in = 1'b0; wq();
      for (int i = 0; i < 9; i++) bus_bit(1'b0);
      wq(3 * Q);
      chk("R6 after stop", out_valid, 0);

      // R7: stop mid-byte, then start mid-byte
      bus_start();
      bus_bit(1); bus_bit(0); bus_bit(1);
      bus_stop();
      bus_start();
      bus_bit(1); bus_bit(1); bus_bit(0); bus_bit(1);
      bus_start();
      bus_byte(8'h5A, 1'b0);
      bus_stop();
      drain_check("R7 partial byte");

      // R11: one-clock glitches on SCL and SDA mid-byte
      bus_start();
      exp_q.push_back(10'h2C3);
      exp_q.push_back(10'h300);
      bus_bit(1); bus_bit(1); bus_bit(0);
      scl_in = 1'b1; @(negedge clk); scl_in = 1'b0; wq();
      bus_bit(0); bus_bit(0);
      sda_in = 1'b1; @(negedge clk); sda_in = 1'b0; wq();
      bus_bit(0); bus_bit(1); bus_bit(1);
      bus_bit(0);
      bus_stop();
      drain_check("R11 glitch filter");

      // R8 R9 R10: fill 4096 tokens with ready held low
      out_ready = 1'b0;
      for (int i = 0; i < 2048; i++) begin
         bus_start();
         bus_stop();
      end
      wq(3 * Q);
      chk("R9 no overflow at exactly full", overflow, 0);
      bus_start(0);
      bus_stop(0);
      wq(3 * Q);
      chk("R9 overflow set", overflow, 1);
      wq(20);
      chk("R10 overflow sticky", overflow, 1);
      out_ready = 1'b1;
      wq(4200);
      chk("R8 all 4096 delivered", exp_q.size(), 0);
      chk("R9 dropped events absent", out_valid, 0);
      chk("R10 sticky after drain", overflow, 1);
      clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0; wq(2);
      chk("R10 cleared", overflow, 0);

      // after clear, normal traffic resumes
      bus_start();
      bus_byte(8'hC3, 1'b0);
      bus_stop();
      drain_check("R1 R2 after clear");

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule